// File: doc/BRIEF.md
# Split-DAC SAR Switching Controller

This block sequences the coarse successive-approximation phase of a differential converter whose capacitor array is divided between two sub-converters. Each sub-converter owns a positive and a negative DAC. Every bottom plate is held as a three-level state: low, mid or high. Once per bit trial the controller raises a comparator strobe and takes one comparator decision. It then updates the plate state vectors.

The first decision chooses the sub-converter that carries on and retires the other. The second decision uses a merged plate pair, which is shifted up on one side, and it also places every remaining plate of the chosen side at its starting level. Every later decision moves exactly one plate down by one level. Eleven coarse bits plus one redundant trial give twelve trials per conversion. A one-cycle start pulse launches a conversion, and a one-cycle done pulse closes it. The plates then stay frozen so that the residue is kept for a later fine stage. The integrator enable stays low for the whole coarse phase.

Top module: `split_sar_ctrl`

## Requirements
- R1: After reset, and in the cycle after an accepted start, the plates have these levels. Sub-converter 1 has every positive plate high and every negative plate low. Sub-converter 0 has every positive plate low and every negative plate high. Both enables and both idle flags are 0 after reset. After an accepted start, both enables are 1 and both idle flags are 0. Levels are encoded low=00, mid=01 and high=10. Plate j of a DAC occupies bits 2j+1:2j of its vector.
- R2: The first decision selects a sub-converter. A 1 selects sub-converter 1 and a 0 selects sub-converter 0. From the next cycle, only the selected sub-converter's enable is 1. The idle flag of the other sub-converter is 1, and it stays 1 until the next start. Bit 1 of each flag pair is sub-converter 1.
- R3: After the first decision, plate 0 of both DACs of the selected sub-converter is mid. The plates of the unselected sub-converter never change for the rest of the conversion.
- R4: At the second decision, plate 0 of the selected sub-converter moves from mid to high. A decision of 1 moves the negative DAC's plate and a decision of 0 moves the positive DAC's plate. The same decision places plates 1 and up: a 1 sets positive to mid and negative to high, and a 0 sets positive to high and negative to mid.
- R5: At trial k, for k from 2 upward, plate k-1 of the selected sub-converter moves down by exactly one level. A decision of 1 moves the positive DAC's plate and a decision of 0 moves the negative DAC's plate. No other plate changes.
- R6: A conversion has exactly 12 trials, which are the 11 coarse bits and one redundant trial. The strobe is high in exactly those 12 consecutive cycles, one per trial. The integrator enable is 0 throughout.
- R7: The code output holds the decisions in trial order, with the first decision in bit 11 and the last in bit 0. It is cleared by an accepted start.
- R8: Done is a one-cycle pulse in the cycle after the last decision is taken. After that cycle, the enables are both 0. The plates and the code stay unchanged, whatever the decision input does, until the next start.
- R9: A start that arrives while a conversion is running is ignored. A start that arrives in the done cycle is accepted and begins a new conversion.
- R10: No plate ever holds the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle conversion launch |
| cmp_dec | input | 1 | Comparator decision for the current trial |
| cmp_strobe | output | 1 | High in each cycle in which a decision is taken |
| int_en | output | 1 | Integrator enable, held 0 in the coarse phase |
| sub_en | output | 2 | Sub-converter enables (bit 1 = sub-converter 1) |
| sub_idle | output | 2 | Sub-converter idle flags for the current conversion |
| plates_p1 | output | 22 | Sub-converter 1 positive DAC plate levels |
| plates_n1 | output | 22 | Sub-converter 1 negative DAC plate levels |
| plates_p0 | output | 22 | Sub-converter 0 positive DAC plate levels |
| plates_n0 | output | 22 | Sub-converter 0 negative DAC plate levels |
| code | output | 12 | Raw coarse decisions, first decision in the top bit |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Two of this block's functions can fall in the same cycle: the end of a conversion and the launch of the next one. Freezing the residue and reloading the plates then compete in the done cycle. The bench provokes this by raising start in the done cycle. It judges the result by the reloaded plate levels, the cleared code and a fully correct second conversion. The bench also raises start mid-conversion and requires the final plates and code to match a run without that pulse. Every one of the 4096 decision patterns, plus a set of ideal-comparator runs, is compared against a plate model built from the switching rules.

// File: rtl/split_sar_pkg.sv
package split_sar_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_t;

  function automatic lvl_t lvl_down(input lvl_t cur);
    case (cur)
      LVL_HIGH: lvl_down = LVL_MID;
      default:  lvl_down = LVL_LOW;
    endcase
  endfunction

endpackage

// File: rtl/split_sar_seq.sv
module split_sar_seq #(
  parameter int NTRIAL = 12,
  localparam int TW = $clog2(NTRIAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [TW-1:0] trial,
  output logic          load,
  output logic          step,
  output logic          last,
  output logic          done
);

  logic          busy_q;
  logic [TW-1:0] trial_q;
  logic          done_q;

  assign load  = start && !busy_q;
  assign step  = busy_q;
  assign last  = busy_q && (trial_q == TW'(NTRIAL - 1));
  assign busy  = busy_q;
  assign trial = trial_q;
  assign done  = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      trial_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q  <= 1'b1;
        trial_q <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          trial_q <= trial_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/split_sar_plates.sv
module split_sar_plates
  import split_sar_pkg::*;
#(
  parameter int NTRIAL = 12,
  localparam int NPLATE = NTRIAL - 1,
  localparam int TW = $clog2(NTRIAL),
  localparam int VW = 2 * NPLATE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [TW-1:0] trial,
  input  logic          dec,
  output logic [VW-1:0] p1_vec,
  output logic [VW-1:0] n1_vec,
  output logic [VW-1:0] p0_vec,
  output logic [VW-1:0] n0_vec
);

  logic          sel_q;
  logic [VW-1:0] pv [2];
  logic [VW-1:0] nv [2];

  always_ff @(posedge clk) begin
    if (rst || load) begin
      sel_q <= 1'b0;
    end else if (step && trial == '0) begin
      sel_q <= dec;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : gen_sub
    localparam lvl_t P_INIT = (s == 1) ? LVL_HIGH : LVL_LOW;
    localparam lvl_t N_INIT = (s == 1) ? LVL_LOW : LVL_HIGH;

    lvl_t p_q [NPLATE];
    lvl_t n_q [NPLATE];
    logic mine;

    assign mine = (trial == '0) ? (dec == 1'(s)) : (sel_q == 1'(s));

    always_ff @(posedge clk) begin
      if (rst || load) begin
        for (int j = 0; j < NPLATE; j++) begin
          p_q[j] <= P_INIT;
          n_q[j] <= N_INIT;
        end
      end else if (step && mine) begin
        if (trial == '0) begin
          p_q[0] <= LVL_MID;
          n_q[0] <= LVL_MID;
        end else if (trial == TW'(1)) begin
          if (dec) n_q[0] <= LVL_HIGH;
          else     p_q[0] <= LVL_HIGH;
          for (int j = 1; j < NPLATE; j++) begin
            p_q[j] <= dec ? LVL_MID : LVL_HIGH;
            n_q[j] <= dec ? LVL_HIGH : LVL_MID;
          end
        end else begin
          for (int j = 1; j < NPLATE; j++) begin
            if (int'(trial) == j + 1) begin
              if (dec) p_q[j] <= lvl_down(p_q[j]);
              else     n_q[j] <= lvl_down(n_q[j]);
            end
          end
        end
      end
    end

    for (genvar j = 0; j < NPLATE; j++) begin : gen_pack
      assign pv[s][2*j +: 2] = p_q[j];
      assign nv[s][2*j +: 2] = n_q[j];
    end
  end

  assign p1_vec = pv[1];
  assign n1_vec = nv[1];
  assign p0_vec = pv[0];
  assign n0_vec = nv[0];

endmodule

// File: rtl/split_sar_flags.sv
module split_sar_flags #(
  parameter int NTRIAL = 12,
  localparam int TW = $clog2(NTRIAL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              last,
  input  logic [TW-1:0]     trial,
  input  logic              dec,
  output logic [NTRIAL-1:0] code,
  output logic [1:0]        sub_en,
  output logic [1:0]        sub_idle
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= '0;
      sub_en   <= 2'b00;
      sub_idle <= 2'b00;
    end else if (load) begin
      code     <= '0;
      sub_en   <= 2'b11;
      sub_idle <= 2'b00;
    end else if (step) begin
      for (int k = 0; k < NTRIAL; k++) begin
        if (int'(trial) == NTRIAL - 1 - k) code[k] <= dec;
      end
      if (trial == '0) begin
        sub_en   <= dec ? 2'b10 : 2'b01;
        sub_idle <= dec ? 2'b01 : 2'b10;
      end
      if (last) sub_en <= 2'b00;
    end
  end

endmodule

// File: rtl/split_sar_ctrl.sv
module split_sar_ctrl #(
  parameter int COARSE_BITS = 11,
  parameter int RED_BITS = 1,
  localparam int NTRIAL = COARSE_BITS + RED_BITS,
  localparam int NPLATE = NTRIAL - 1,
  localparam int TW = $clog2(NTRIAL)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                cmp_dec,
  output logic                cmp_strobe,
  output logic                int_en,
  output logic [1:0]          sub_en,
  output logic [1:0]          sub_idle,
  output logic [2*NPLATE-1:0] plates_p1,
  output logic [2*NPLATE-1:0] plates_n1,
  output logic [2*NPLATE-1:0] plates_p0,
  output logic [2*NPLATE-1:0] plates_n0,
  output logic [NTRIAL-1:0]   code,
  output logic                done
);

  logic          busy;
  logic [TW-1:0] trial;
  logic          load;
  logic          step;
  logic          last;

  split_sar_seq #(.NTRIAL(NTRIAL)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .trial(trial),
    .load(load), .step(step), .last(last), .done(done)
  );

  split_sar_plates #(.NTRIAL(NTRIAL)) u_plates (
    .clk(clk), .rst(rst), .load(load), .step(step), .trial(trial),
    .dec(cmp_dec), .p1_vec(plates_p1), .n1_vec(plates_n1),
    .p0_vec(plates_p0), .n0_vec(plates_n0)
  );

  split_sar_flags #(.NTRIAL(NTRIAL)) u_flags (
    .clk(clk), .rst(rst), .load(load), .step(step), .last(last),
    .trial(trial), .dec(cmp_dec), .code(code), .sub_en(sub_en),
    .sub_idle(sub_idle)
  );

  assign cmp_strobe = busy;
  assign int_en     = 1'b0;

endmodule

// File: rtl/split_sar_ctrl_chk.sv
module split_sar_ctrl_chk #(
  parameter int NPLATE = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                cmp_strobe,
  input logic                done,
  input logic [1:0]          sub_en,
  input logic [1:0]          sub_idle,
  input logic [2*NPLATE-1:0] plates_p1,
  input logic [2*NPLATE-1:0] plates_n1,
  input logic [2*NPLATE-1:0] plates_p0,
  input logic [2*NPLATE-1:0] plates_n0
);

  function automatic logic has_bad(input logic [2*NPLATE-1:0] v);
    has_bad = 1'b0;
    for (int j = 0; j < NPLATE; j++) begin
      if (v[2*j +: 2] == 2'b11) has_bad = 1'b1;
    end
  endfunction

  // R10
  no_illegal_level_chk: assert property (@(posedge clk) disable iff (rst)
    !(has_bad(plates_p1) || has_bad(plates_n1) || has_bad(plates_p0) || has_bad(plates_n0)));

  // R2
  idle_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sub_idle) && ((sub_en & sub_idle) == 2'b00));

  // R3
  idle_sub_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_idle[0] && $past(sub_idle[0])) |-> ($stable(plates_p0) && $stable(plates_n0)));

  // R8
  residue_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cmp_strobe) && !$past(start)) |->
      ($stable(plates_p1) && $stable(plates_n1) && $stable(plates_p0) && $stable(plates_n0)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  no_strobe_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmp_strobe);

endmodule

bind split_sar_ctrl split_sar_ctrl_chk #(.NPLATE(NPLATE)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cmp_strobe(cmp_strobe), .done(done),
  .sub_en(sub_en), .sub_idle(sub_idle), .plates_p1(plates_p1),
  .plates_n1(plates_n1), .plates_p0(plates_p0), .plates_n0(plates_n0)
);

// File: tb/tb_split_sar_ctrl.sv
`timescale 1ns/1ps
module tb_split_sar_ctrl;

  localparam int NT = 12;
  localparam int NP = NT - 1;
  localparam int VW = 2 * NP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_dec = 1'b0;
  logic cmp_strobe, int_en, done;
  logic [1:0] sub_en, sub_idle;
  logic [VW-1:0] plates_p1, plates_n1, plates_p0, plates_n0;
  logic [NT-1:0] code;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  split_sar_ctrl #(.COARSE_BITS(11), .RED_BITS(1)) dut (
    .clk(clk), .rst(rst), .start(start), .cmp_dec(cmp_dec),
    .cmp_strobe(cmp_strobe), .int_en(int_en), .sub_en(sub_en),
    .sub_idle(sub_idle), .plates_p1(plates_p1), .plates_n1(plates_n1),
    .plates_p0(plates_p0), .plates_n0(plates_n0), .code(code), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] fill(input int lvl);
    logic [VW-1:0] v;
    for (int j = 0; j < NP; j++) v[2*j +: 2] = 2'(lvl);
    return v;
  endfunction

  logic [VW-1:0] e_p [2];
  logic [VW-1:0] e_n [2];

  // expected plates from the switching rules (R1, R3, R4, R5)
  task automatic model(input logic [NT-1:0] c);
    int lp [2][NP];
    int ln [2][NP];
    int s;
    for (int j = 0; j < NP; j++) begin
      lp[1][j] = 2; ln[1][j] = 0; lp[0][j] = 0; ln[0][j] = 2;
    end
    s = c[NT-1];
    lp[s][0] = 1; ln[s][0] = 1;
    if (c[NT-2]) ln[s][0] = 2; else lp[s][0] = 2;
    for (int j = 1; j < NP; j++) begin
      lp[s][j] = c[NT-2] ? 1 : 2;
      ln[s][j] = c[NT-2] ? 2 : 1;
    end
    for (int t = 2; t < NT; t++) begin
      if (c[NT-1-t]) lp[s][t-1] = (lp[s][t-1] > 0) ? lp[s][t-1] - 1 : 0;
      else           ln[s][t-1] = (ln[s][t-1] > 0) ? ln[s][t-1] - 1 : 0;
    end
    for (int q = 0; q < 2; q++)
      for (int j = 0; j < NP; j++) begin
        e_p[q][2*j +: 2] = 2'(lp[q][j]);
        e_n[q][2*j +: 2] = 2'(ln[q][j]);
      end
  endtask

  // ideal comparator: sign of input plus DAC-weighted shift of the chosen side
  function automatic logic ideal_cmp(input int vin, input int t, input logic s);
    int r;
    logic [VW-1:0] pv, nv, p0v, n0v;
    r = vin;
    if (t == 0) return (vin > 0);
    pv  = s ? plates_p1 : plates_p0;
    nv  = s ? plates_n1 : plates_n0;
    p0v = s ? fill(2) : fill(0);
    n0v = s ? fill(0) : fill(2);
    for (int j = 0; j < NP; j++)
      r += (1 << (NP - 1 - j)) *
           ((int'(pv[2*j +: 2]) - int'(p0v[2*j +: 2])) -
            (int'(nv[2*j +: 2]) - int'(n0v[2*j +: 2])));
    return (r > 0);
  endfunction

  task automatic check_init(input string tag);
    chk(plates_p1 == fill(2), {tag, " R1 p1"}, 64'(plates_p1), 64'(fill(2)));
    chk(plates_n1 == fill(0), {tag, " R1 n1"}, 64'(plates_n1), 64'(fill(0)));
    chk(plates_p0 == fill(0), {tag, " R1 p0"}, 64'(plates_p0), 64'(fill(0)));
    chk(plates_n0 == fill(2), {tag, " R1 n0"}, 64'(plates_n0), 64'(fill(2)));
  endtask

  task automatic launch();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_init("start");
    chk(sub_en == 2'b11 && sub_idle == 2'b00 && code == '0, "R1 R7 flags after start",
        64'({sub_en, sub_idle, code}), 64'({2'b11, 2'b00, 12'h0}));
  endtask

  // drives one conversion from the cycle of trial 0 to the done cycle
  task automatic convey(input logic [NT-1:0] pat, input bit closed, input int vin,
                        input bit mid_start, input bit frz);
    logic [NT-1:0] d;
    int strobes = 0;
    logic [VW-1:0] k1, k2, k3, k4;
    logic [NT-1:0] kc;
    for (int t = 0; t < NT; t++) begin
      if (cmp_strobe) strobes++;
      if (int_en) strobes += 100;
      d[NT-1-t] = closed ? ideal_cmp(vin, t, d[NT-1]) : pat[NT-1-t];
      cmp_dec = d[NT-1-t];
      start = (mid_start && t == 5);
      @(negedge clk);
      start = 1'b0;
      if (t == 0)
        chk(sub_en == (d[NT-1] ? 2'b10 : 2'b01) && sub_idle == (d[NT-1] ? 2'b01 : 2'b10),
            "R2 select", 64'({sub_en, sub_idle}),
            64'({d[NT-1] ? 4'b1001 : 4'b0110}));
    end
    chk(strobes == NT && !cmp_strobe, "R6 strobe count", 64'(strobes), 64'(NT));
    chk(done == 1'b1, "R8 done pulse", 64'(done), 64'(1));
    chk(code == d, "R7 code", 64'(code), 64'(d));
    if (closed) chk(code[NT-1] == (vin > 0), "R2 polarity", 64'(code[NT-1]), 64'(vin > 0));
    model(d);
    chk(plates_p1 == e_p[1], "R3 R4 R5 p1", 64'(plates_p1), 64'(e_p[1]));
    chk(plates_n1 == e_n[1], "R3 R4 R5 n1", 64'(plates_n1), 64'(e_n[1]));
    chk(plates_p0 == e_p[0], "R3 R4 R5 p0", 64'(plates_p0), 64'(e_p[0]));
    chk(plates_n0 == e_n[0], "R3 R4 R5 n0", 64'(plates_n0), 64'(e_n[0]));
    if (frz) begin
      k1 = plates_p1; k2 = plates_n1; k3 = plates_p0; k4 = plates_n0; kc = code;
      for (int i = 0; i < 3; i++) begin
        cmp_dec = ~cmp_dec;
        @(negedge clk);
        chk(!done && sub_en == 2'b00 && plates_p1 == k1 && plates_n1 == k2 &&
            plates_p0 == k3 && plates_n0 == k4 && code == kc, "R8 frozen",
            64'({done, sub_en, code}), 64'({1'b0, 2'b00, kc}));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_init("reset");
    chk(sub_en == 2'b00 && sub_idle == 2'b00 && !done && !cmp_strobe && code == '0,
        "R1 R6 reset flags", 64'({sub_en, sub_idle, done, cmp_strobe, code}), 64'(0));
    // exhaustive sweep over all decision patterns (R10 watched by the checker)
    for (int p = 0; p < (1 << NT); p++) begin
      launch();
      convey(NT'(p), 1'b0, 0, (p % 37) == 3, 1'b1);
    end
    // ideal-comparator runs across the input range
    for (int v = -4000; v <= 4000; v += 250) begin
      launch();
      convey('0, 1'b1, v, 1'b0, 1'b1);
    end
    // R9: start raised in the done cycle begins a new conversion at once
    for (int b = 0; b < 8; b++) begin
      launch();
      convey(NT'(b * 517 + 2048), 1'b0, 0, 1'b0, 1'b0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_init("R9 back-to-back");
      chk(code == '0 && cmp_strobe && !done, "R9 restart flags",
          64'({code, cmp_strobe, done}), 64'({12'h0, 1'b1, 1'b0}));
      convey(NT'(b * 1201 + 77), 1'b0, 0, 1'b1, 1'b1);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule